// File: doc/BRIEF.md
# Processor-Side Interrupt Acknowledge Interface

This block sits between an interrupt distributor and a single processor. The distributor presents its best pending interrupt as an ID, a priority value and, for software interrupts, the number of the requesting CPU. The block filters that candidate against a priority mask and against the priority of the interrupts already in service. When the candidate qualifies, the block raises an IRQ line to the processor.

The processor reads an acknowledge register to take the interrupt. The read returns the ID, records the interrupt as active, raises the running priority to the interrupt's priority, and sends a one-cycle pulse to the distributor so that it can clear the pending state. The processor writes the same value to a completion register when its handler finishes. A matching write retires the active entry and sends a completion pulse. A small table of active entries holds the nested interrupts. The running priority is the lowest priority value among the valid entries, or 0xFF when the table is empty.

Register access is a single-cycle strobe with a byte offset. Read data is registered and appears on the cycle after the strobe. The IRQ line and both pulses are also registered, so they follow their cause by one cycle.

Top module: `irq_cpu_iface`

## Requirements
- R1: After reset the IRQ line is low, the control register reads 0, the priority mask (offset 0x04) reads 0, and the running priority (offset 0x14) reads 0xFF.
- R2: While bit 0 of the control register (offset 0x00) is clear, the IRQ line stays low and an acknowledge read returns 0x3FF.
- R3: One cycle after the inputs allow it, the IRQ line is high. This requires the candidate to be valid, its priority value to be strictly below the mask, its priority value to be strictly below the running priority, and a free slot to exist in the active table. An equal value does not qualify.
- R4: An acknowledge read (offset 0x0C) of a qualifying candidate returns the ID in bits [9:0]. For IDs 0 to 15 it also returns the source CPU in bits [12:10]; for other IDs those bits are zero. The read also pulses the acknowledge output with that ID, and the running priority becomes the candidate's priority.
- R5: An acknowledge read with no qualifying candidate returns 0x3FF. It produces no acknowledge pulse and leaves the running priority unchanged.
- R6: A highest-pending read (offset 0x18) returns the same value an acknowledge read would return, but it neither pulses nor changes state.
- R7: A write to the completion register (offset 0x10) that matches an active entry retires that entry. For IDs of 16 and above the ID must match. For IDs 0 to 15, bits [12:10] must also equal the recorded source. The write pulses the completion output with the ID and restores the running priority from the remaining entries.
- R8: A completion write whose ID is not active, or whose source bits differ for an ID of 15 or below, is ignored. It produces no pulse and the running priority is unchanged.
- R9: The identification register (offset 0xFC) returns the implementer code in [11:0], the revision in [15:12], the architecture in [19:16] and the product number in [31:20]. With the defaults it reads 0x0C7235A1.
- R10: The binary point register (offset 0x08) stores 3 bits and reads them back. Its value does not affect signalling.
- R11: Once the active table holds SLOTS entries (default 4), no candidate qualifies until one entry retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| dist_valid | input | 1 | Distributor offers a candidate |
| dist_id | input | 10 | Candidate interrupt ID |
| dist_prio | input | 8 | Candidate priority, lower value is more urgent |
| dist_src | input | 3 | Requesting CPU for IDs 0 to 15 |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_valid_o | output | 1 | Pulse: a candidate was acknowledged |
| ack_id_o | output | 10 | ID of the acknowledged interrupt |
| done_valid_o | output | 1 | Pulse: an active interrupt was retired |
| done_id_o | output | 10 | ID of the retired interrupt |

## Verification
The bench targets the priority comparisons at their edges. A candidate whose priority equals the mask, or equals the running priority, must not raise the line; a design using a non-strict compare would signal there. For software interrupts, the bench sends a completion write with the wrong source and another with an ID that is not active. A design that matches on the ID alone would retire the entry early and drop the running priority. The bench also fills the active table, to catch a design that overwrites an entry, and mixes highest-pending reads with acknowledges, to catch a peek that allocates state.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int ID_W   = 10;
  localparam int CPU_W  = 3;
  localparam int PRIO_W = 8;
  localparam int SGI_LIMIT = 16;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MASK  = 8'h04;
  localparam logic [7:0] OFS_BINPT = 8'h08;
  localparam logic [7:0] OFS_ACK   = 8'h0C;
  localparam logic [7:0] OFS_DONE  = 8'h10;
  localparam logic [7:0] OFS_RUN   = 8'h14;
  localparam logic [7:0] OFS_PEEK  = 8'h18;
  localparam logic [7:0] OFS_IDENT = 8'hFC;

  localparam logic [ID_W-1:0] SPURIOUS = 10'h3FF;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [CPU_W-1:0]  src;
    logic [PRIO_W-1:0] prio;
  } act_entry_t;
endpackage

// File: rtl/irq_prio_filter.sv
module irq_prio_filter
  import irq_ack_pkg::*;
(
  input  logic              en,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [CPU_W-1:0]  cand_src,
  input  logic [PRIO_W-1:0] mask,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic              has_free,
  output logic              qual,
  output logic [31:0]       ack_word
);
  logic is_sgi;

  always_comb begin
    is_sgi = cand_id < ID_W'(SGI_LIMIT);
    qual   = en && cand_valid && (cand_prio < mask) &&
             (cand_prio < run_prio) && has_free;
    if (qual)
      ack_word = {19'd0, (is_sgi ? cand_src : {CPU_W{1'b0}}), cand_id};
    else
      ack_word = {22'd0, SPURIOUS};
  end
endmodule

// File: rtl/irq_active_tbl.sv
module irq_active_tbl
  import irq_ack_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  act_entry_t        alloc_entry,
  input  logic              retire,
  input  logic [ID_W-1:0]   retire_id,
  input  logic [CPU_W-1:0]  retire_src,
  output logic              has_free,
  output logic              retire_hit,
  output logic [PRIO_W-1:0] run_prio
);
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0] vld;
  act_entry_t       ent [SLOTS];
  logic [SLOTS-1:0] hit;
  logic [IW-1:0]    free_idx;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    run_prio = '1;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        has_free = 1'b1;
        free_idx = IW'(i);
      end
    end
    for (int i = 0; i < SLOTS; i++) begin
      if (vld[i] && ent[i].prio < run_prio) run_prio = ent[i].prio;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_hit
    assign hit[g] = vld[g] && (ent[g].id == retire_id) &&
                    ((ent[g].id >= ID_W'(SGI_LIMIT)) || (ent[g].src == retire_src));
  end
  assign retire_hit = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (retire && hit[i]) vld[i] <= 1'b0;
        if (alloc && has_free && (free_idx == IW'(i))) begin
          vld[i] <= 1'b1;
          ent[i] <= alloc_entry;
        end
      end
    end
  end
endmodule

// File: rtl/irq_cpu_iface.sv
module irq_cpu_iface
  import irq_ack_pkg::*;
#(
  parameter int          SLOTS     = 4,
  parameter logic [11:0] IMPL_CODE = 12'h5A1,
  parameter logic [3:0]  REV_CODE  = 4'h3,
  parameter logic [3:0]  ARCH_CODE = 4'h2,
  parameter logic [11:0] PART_CODE = 12'h0C7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        dist_valid,
  input  logic [9:0]  dist_id,
  input  logic [7:0]  dist_prio,
  input  logic [2:0]  dist_src,
  output logic        irq_o,
  output logic        ack_valid_o,
  output logic [9:0]  ack_id_o,
  output logic        done_valid_o,
  output logic [9:0]  done_id_o
);
  logic              ctrl_en;
  logic [PRIO_W-1:0] pmr;
  logic [2:0]        bpr;
  logic              qual, has_free, retire_hit;
  logic [PRIO_W-1:0] run_prio;
  logic [31:0]       ack_word;
  logic              take, retire;
  act_entry_t        new_ent;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[31:13];
  assign take    = reg_rd && (reg_addr == OFS_ACK) && qual;
  assign retire  = reg_wr && (reg_addr == OFS_DONE);
  assign new_ent = '{id: dist_id, src: dist_src, prio: dist_prio};

  irq_prio_filter u_filter (
    .en(ctrl_en), .cand_valid(dist_valid), .cand_id(dist_id),
    .cand_prio(dist_prio), .cand_src(dist_src), .mask(pmr),
    .run_prio(run_prio), .has_free(has_free), .qual(qual),
    .ack_word(ack_word)
  );

  irq_active_tbl #(.SLOTS(SLOTS)) u_tbl (
    .clk(clk), .rst(rst), .alloc(take), .alloc_entry(new_ent),
    .retire(retire), .retire_id(reg_wdata[9:0]),
    .retire_src(reg_wdata[12:10]), .has_free(has_free),
    .retire_hit(retire_hit), .run_prio(run_prio)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en      <= 1'b0;
      pmr          <= '0;
      bpr          <= '0;
      reg_rdata    <= '0;
      irq_o        <= 1'b0;
      ack_valid_o  <= 1'b0;
      ack_id_o     <= '0;
      done_valid_o <= 1'b0;
      done_id_o    <= '0;
    end else begin
      irq_o        <= qual;
      ack_valid_o  <= take;
      ack_id_o     <= dist_id;
      done_valid_o <= retire && retire_hit;
      done_id_o    <= reg_wdata[9:0];
      if (reg_wr) begin
        case (reg_addr)
          OFS_CTRL:  ctrl_en <= reg_wdata[0];
          OFS_MASK:  pmr     <= reg_wdata[PRIO_W-1:0];
          OFS_BINPT: bpr     <= reg_wdata[2:0];
          default: ;
        endcase
      end
      if (reg_rd) begin
        case (reg_addr)
          OFS_CTRL:  reg_rdata <= {31'd0, ctrl_en};
          OFS_MASK:  reg_rdata <= {24'd0, pmr};
          OFS_BINPT: reg_rdata <= {29'd0, bpr};
          OFS_ACK:   reg_rdata <= ack_word;
          OFS_PEEK:  reg_rdata <= ack_word;
          OFS_RUN:   reg_rdata <= {24'd0, run_prio};
          OFS_IDENT: reg_rdata <= {PART_CODE, ARCH_CODE, REV_CODE, IMPL_CODE};
          default:   reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_cpu_iface_chk.sv
module irq_cpu_iface_chk
  import irq_ack_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        reg_rd,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic        irq_o,
  input logic        ack_valid_o,
  input logic        done_valid_o,
  input logic        ctrl_en,
  input logic [7:0]  pmr,
  input logic [7:0]  dist_prio,
  input logic        dist_valid,
  input logic        qual
);
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !irq_o);

  a_r3_below_mask: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(dist_valid && (dist_prio < pmr)));

  a_r4_ack_from_read: assert property (@(posedge clk) disable iff (rst)
    ack_valid_o |-> $past(reg_rd && reg_addr == OFS_ACK));

  a_r5_spurious: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_ACK && !qual) |=>
      (!ack_valid_o && reg_rdata[9:0] == SPURIOUS));

  a_r6_peek_no_ack: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_PEEK && !(reg_addr == OFS_ACK)) |=> !ack_valid_o);

  a_r7_done_from_write: assert property (@(posedge clk) disable iff (rst)
    done_valid_o |-> $past(reg_wr && reg_addr == OFS_DONE));
endmodule

bind irq_cpu_iface irq_cpu_iface_chk u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq_o(irq_o),
  .ack_valid_o(ack_valid_o), .done_valid_o(done_valid_o),
  .ctrl_en(ctrl_en), .pmr(pmr), .dist_prio(dist_prio),
  .dist_valid(dist_valid), .qual(qual)
);

// File: tb/irq_cpu_iface_tb.sv
`timescale 1ns/1ps
module irq_cpu_iface_tb;
  localparam int SLOTS = 4;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        dist_valid = 0;
  logic [9:0]  dist_id = 0;
  logic [7:0]  dist_prio = 8'hFF;
  logic [2:0]  dist_src = 0;
  logic        irq_o, ack_valid_o, done_valid_o;
  logic [9:0]  ack_id_o, done_id_o;

  always #2 clk = ~clk;

  irq_cpu_iface #(.SLOTS(SLOTS)) u_dut (.*);

  typedef struct { int id; int src; int prio; } ent_t;
  ent_t q[$];
  int   m_en = 0, m_pmr = 0, m_bpr = 0;
  int   nvec = 0, nerr = 0;
  bit   done_flag = 0;
  string cur_req = "R1";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, tag, act, exp);
    end
  endtask

  function automatic int run_prio();
    int r = 255;
    foreach (q[i]) if (q[i].prio < r) r = q[i].prio;
    return r;
  endfunction

  task automatic cyc();
    int r = run_prio();
    bit qual = m_en != 0 && dist_valid && dist_prio < m_pmr && dist_prio < r && q.size() < SLOTS;
    logic [31:0] word = qual ? ((dist_id < 16) ? {19'd0, dist_src, dist_id} : {22'd0, dist_id})
                             : 32'h3FF;
    logic [31:0] e_rd = 0;
    bit e_ack = 0, e_done = 0;
    int e_ack_id = 0, e_done_id = 0;
    if (reg_rd) begin
      case (reg_addr)
        8'h00: e_rd = m_en;
        8'h04: e_rd = m_pmr;
        8'h08: e_rd = m_bpr;
        8'h0C, 8'h18: e_rd = word;
        8'h14: e_rd = r;
        8'hFC: e_rd = {12'h0C7, 4'h2, 4'h3, 12'h5A1};
        default: e_rd = 0;
      endcase
      if (reg_addr == 8'h0C && qual) begin
        e_ack = 1; e_ack_id = dist_id;
        q.push_back('{dist_id, dist_src, dist_prio});
      end
    end
    if (reg_wr) begin
      case (reg_addr)
        8'h00: m_en = reg_wdata[0];
        8'h04: m_pmr = reg_wdata[7:0];
        8'h08: m_bpr = reg_wdata[2:0];
        8'h10: begin
          for (int i = q.size() - 1; i >= 0; i--)
            if (q[i].id == reg_wdata[9:0] && (q[i].id >= 16 || q[i].src == reg_wdata[12:10])) begin
              q.delete(i); e_done = 1; e_done_id = reg_wdata[9:0];
            end
        end
        default: ;
      endcase
    end
    begin
      bit rd_now = reg_rd;
      @(posedge clk); #1;
      chk("irq", irq_o, qual);
      chk("ack_valid", ack_valid_o, e_ack);
      if (e_ack) chk("ack_id", ack_id_o, e_ack_id);
      chk("done_valid", done_valid_o, e_done);
      if (e_done) chk("done_id", done_id_o, e_done_id);
      if (rd_now) chk("rdata", reg_rdata, e_rd);
      @(negedge clk);
    end
  endtask

  task automatic rd(logic [7:0] a);
    reg_rd = 1; reg_addr = a; cyc(); reg_rd = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; cyc(); reg_wr = 0;
  endtask

  task automatic offer(int id, int prio, int src);
    dist_valid = 1; dist_id = id; dist_prio = prio; dist_src = src;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    cur_req = "R1";
    chk("irq_reset", irq_o, 0);
    rd(8'h14); rd(8'h04); rd(8'h00);
    cur_req = "R9";
    rd(8'hFC);
    cur_req = "R10";
    wr(8'h08, 5); rd(8'h08); wr(8'h08, 32'hFF); rd(8'h08);
    cur_req = "R2";
    wr(8'h04, 8'hFF);
    offer(40, 8'h20, 0);
    cyc(); cyc(); rd(8'h0C);
    cur_req = "R3";
    wr(8'h00, 1); cyc();
    wr(8'h04, 8'h20); cyc(); cyc();
    wr(8'h04, 8'h21); cyc();
    cur_req = "R6";
    rd(8'h18); rd(8'h18); rd(8'h14);
    cur_req = "R4";
    rd(8'h0C); rd(8'h14); cyc();
    cur_req = "R5";
    offer(5, 8'h20, 3);
    cyc(); rd(8'h0C); rd(8'h14);
    cur_req = "R4";
    offer(5, 8'h10, 3);
    cyc(); rd(8'h18); rd(8'h0C); rd(8'h14);
    dist_valid = 0;
    cur_req = "R8";
    wr(8'h10, 5); rd(8'h14);
    wr(8'h10, {19'd0, 3'd2, 10'd5}); rd(8'h14);
    wr(8'h10, 41); rd(8'h14);
    cur_req = "R7";
    wr(8'h10, {19'd0, 3'd3, 10'd5}); rd(8'h14);
    wr(8'h10, 40); rd(8'h14);
    cur_req = "R11";
    wr(8'h04, 8'hFF);
    for (int k = 0; k < SLOTS; k++) begin
      offer(100 + k, 8'h40 - 8 * k, 0); cyc(); rd(8'h0C);
    end
    offer(200, 8'h01, 0); cyc(); rd(8'h0C); rd(8'h18);
    wr(8'h10, 101); cyc(); rd(8'h0C); rd(8'h14);
    cur_req = "R5";
    dist_valid = 0; cyc(); rd(8'h0C);
    repeat (2) cyc();
    finish_run();
  end
endmodule